// File: doc/BRIEF.md
# CPU Bus Target Decoder with Memory-First Fallback

This unit sits on the processor side of a system bus and works out which target serves each CPU read or write. The CPU presents an address, a read or write strobe, and a space-select line that picks port space or memory space. Port-space accesses use a narrow port number. Ports inside a configured range hit a small bank of device control registers held in the block. Any other port is passed to the external I/O bus. Memory-space accesses that land in a configured window hit a local data buffer. Any other memory address is offered to the dedicated memory bus first.

The memory bus and the I/O bus do not see each other's traffic. If memory does not acknowledge within a bounded number of cycles, the same access is reissued on the I/O bus. An access that neither bus answers completes with a bus-error flag, so the CPU is never left waiting. Only one bus request is active at a time, so two targets can never both claim an access.

Top module: `bus_space_responder`

## Requirements
- R1: After reset, cpuDone, cpuBusErr, memReq and ioReq are low and cpuRdata is zero.
- R2: A port-space access whose port number lies in [REG_BASE, REG_BASE+NUM_REGS) reads or writes a local register. cpuDone pulses in the cycle after the strobe, and no bus request is raised.
- R3: A memory-space access whose address lies in [WIN_BASE, WIN_BASE+WIN_WORDS) reads or writes the local data buffer. cpuDone pulses in the cycle after the strobe, and no bus request is raised.
- R4: A memory-space access outside the window raises memReq in the cycle after the strobe, carrying the address, the write flag and the write data. The cycle after memAck is sampled, cpuDone pulses, and a read returns memRdata.
- R5: If memAck has not come by the TIMEOUT-th cycle of memReq, memReq drops and ioReq carries the same address and direction in the next cycle.
- R6: A port-space access outside the register range goes straight to the I/O bus, with ioAddr equal to the zero-extended port number. memReq is never raised for it.
- R7: If ioAck has not come by the TIMEOUT-th cycle of ioReq, cpuDone and cpuBusErr pulse together in the next cycle, and cpuRdata keeps its previous value.
- R8: memReq and ioReq are never high in the same cycle.
- R9: A strobe that arrives while a bus request is still open is ignored. The open access completes unchanged, and no extra completion follows.
- R10: If cpuRead and cpuWrite are high together, the access is a write. A write never changes cpuRdata.
- R11: Only the low PORT_W bits of cpuAddr form the port number in port space; the upper bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | ADDR_W | CPU address, or port number in its low PORT_W bits |
| cpuIoSpace | input | 1 | 1 selects port space, 0 selects memory space |
| cpuRead | input | 1 | One-cycle read strobe |
| cpuWrite | input | 1 | One-cycle write strobe |
| cpuWdata | input | DATA_W | Write data |
| cpuRdata | output | DATA_W | Data of the last completed read |
| cpuDone | output | 1 | One-cycle completion pulse |
| cpuBusErr | output | 1 | Set with cpuDone when no target answered |
| memReq | output | 1 | Memory bus request |
| memWe | output | 1 | Memory bus write flag |
| memAddr | output | ADDR_W | Memory bus address |
| memWdata | output | DATA_W | Memory bus write data |
| memAck | input | 1 | Memory acknowledge |
| memRdata | input | DATA_W | Memory read data |
| ioReq | output | 1 | I/O bus request |
| ioWe | output | 1 | I/O bus write flag |
| ioAddr | output | ADDR_W | I/O bus address |
| ioWdata | output | DATA_W | I/O bus write data |
| ioAck | input | 1 | I/O acknowledge |
| ioRdata | input | DATA_W | I/O read data |

## Verification
A local register or buffer hit completes one cycle after the strobe. A memory answer with acknowledge delay d completes d+2 cycles after the strobe. A fallback adds TIMEOUT cycles of memory request before the I/O phase, and a double miss ends with the error pulse 2·TIMEOUT+1 cycles after the strobe (TIMEOUT+1 for a port access, which skips memory). The bench works out these cycle numbers from the address, the space and the responder delays it has set. It samples every output at the falling edge of each cycle after the strobe, up to one cycle past the expected completion, so a late, early or repeated completion, or a request held one cycle too long, is caught.

// File: rtl/busresp_pkg.sv
package busresp_pkg;

  typedef enum logic [1:0] {
    TGT_REG,
    TGT_BUF,
    TGT_MEM,
    TGT_IO
  } targetE;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MEM,
    ST_IO
  } stateE;

  typedef struct packed {
    logic capture;
    logic localWr;
    logic localRd;
    logic memLoad;
    logic ioLoad;
  } strobeT;

endpackage

// File: rtl/busresp_datapath.sv
module busresp_datapath
  import busresp_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int PORT_W    = 8,
  parameter int REG_BASE  = 'h40,
  parameter int NUM_REGS  = 4,
  parameter int WIN_BASE  = 'hF000,
  parameter int WIN_WORDS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic              cpuIoSpace,
  input  strobeT            strobes,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] ioRdata,
  output targetE            target,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] ioAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int REG_IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int WIN_IDX_W = (WIN_WORDS > 1) ? $clog2(WIN_WORDS) : 1;
  localparam logic [31:0] REG_LO = REG_BASE;
  localparam logic [31:0] REG_HI = REG_BASE + NUM_REGS;
  localparam logic [31:0] WIN_LO = WIN_BASE;
  localparam logic [31:0] WIN_HI = WIN_BASE + WIN_WORDS;

  logic [PORT_W-1:0]    portNum;
  logic                 regHit;
  logic                 bufHit;
  logic [REG_IDX_W-1:0] regIdx;
  logic [WIN_IDX_W-1:0] bufIdx;
  logic [DATA_W-1:0]    localData;

  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic [DATA_W-1:0] bufMem  [WIN_WORDS];

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic              portQ;

  // Address decode, taken from the live CPU inputs in the strobe cycle
  always_comb begin
    portNum = cpuAddr[PORT_W-1:0];
    regHit  = (32'(portNum) >= REG_LO) && (32'(portNum) < REG_HI);
    bufHit  = (32'(cpuAddr) >= WIN_LO) && (32'(cpuAddr) < WIN_HI);
    regIdx  = REG_IDX_W'(32'(portNum) - REG_LO);
    bufIdx  = WIN_IDX_W'(32'(cpuAddr) - WIN_LO);
    if (cpuIoSpace) target = regHit ? TGT_REG : TGT_IO;
    else            target = bufHit ? TGT_BUF : TGT_MEM;
    localData = cpuIoSpace ? regFile[regIdx] : bufMem[bufIdx];
  end

  // Device control registers (port space)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else if (strobes.localWr && cpuIoSpace) begin
      regFile[regIdx] <= cpuWdata;
    end
  end

  // Data buffer window (memory space)
  always_ff @(posedge clk) begin
    if (strobes.localWr && !cpuIoSpace) bufMem[bufIdx] <= cpuWdata;
  end

  // Access capture for the external buses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      portQ  <= 1'b0;
    end else if (strobes.capture) begin
      addrQ  <= cpuAddr;
      wdataQ <= cpuWdata;
      portQ  <= cpuIoSpace;
    end
  end

  // Read data return
  always_ff @(posedge clk) begin
    if (!rstN)                rdata <= '0;
    else if (strobes.localRd) rdata <= localData;
    else if (strobes.memLoad) rdata <= memRdata;
    else if (strobes.ioLoad)  rdata <= ioRdata;
  end

  assign memAddr  = addrQ;
  assign ioAddr   = portQ ? ADDR_W'(addrQ[PORT_W-1:0]) : addrQ;
  assign busWdata = wdataQ;

endmodule

// File: rtl/busresp_control.sv
module busresp_control
  import busresp_pkg::*;
#(
  parameter int TIMEOUT = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   isWrite,
  input  targetE target,
  input  logic   memAck,
  input  logic   ioAck,
  output strobeT strobes,
  output logic   memReq,
  output logic   ioReq,
  output logic   busWe,
  output logic   cpuDone,
  output logic   cpuBusErr
);

  localparam int CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  stateE            state, stateN;
  logic [CNT_W-1:0] cnt, cntN;
  logic             weQ, weN;
  logic             doneN, errN;

  always_comb begin
    strobes = '0;
    stateN  = state;
    cntN    = cnt;
    weN     = weQ;
    doneN   = 1'b0;
    errN    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobes.capture = 1'b1;
          weN  = isWrite;
          cntN = '0;
          unique case (target)
            TGT_REG, TGT_BUF: begin
              strobes.localWr = isWrite;
              strobes.localRd = !isWrite;
              doneN = 1'b1;
            end
            TGT_MEM: stateN = ST_MEM;
            default: stateN = ST_IO;
          endcase
        end
      end
      ST_MEM: begin
        if (memAck) begin
          strobes.memLoad = !weQ;
          doneN  = 1'b1;
          stateN = ST_IDLE;
        end else if (cnt == LAST) begin
          stateN = ST_IO;
          cntN   = '0;
        end else begin
          cntN = cnt + CNT_W'(1);
        end
      end
      ST_IO: begin
        if (ioAck) begin
          strobes.ioLoad = !weQ;
          doneN  = 1'b1;
          stateN = ST_IDLE;
        end else if (cnt == LAST) begin
          doneN  = 1'b1;
          errN   = 1'b1;
          stateN = ST_IDLE;
        end else begin
          cntN = cnt + CNT_W'(1);
        end
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      weQ       <= 1'b0;
      cpuDone   <= 1'b0;
      cpuBusErr <= 1'b0;
    end else begin
      state     <= stateN;
      cnt       <= cntN;
      weQ       <= weN;
      cpuDone   <= doneN;
      cpuBusErr <= errN;
    end
  end

  assign memReq = (state == ST_MEM);
  assign ioReq  = (state == ST_IO);
  assign busWe  = weQ;

endmodule

// File: rtl/bus_space_responder.sv
module bus_space_responder
  import busresp_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int PORT_W    = 8,
  parameter int REG_BASE  = 'h40,
  parameter int NUM_REGS  = 4,
  parameter int WIN_BASE  = 'hF000,
  parameter int WIN_WORDS = 16,
  parameter int TIMEOUT   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuIoSpace,
  input  logic              cpuRead,
  input  logic              cpuWrite,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuDone,
  output logic              cpuBusErr,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  output logic              ioReq,
  output logic              ioWe,
  output logic [ADDR_W-1:0] ioAddr,
  output logic [DATA_W-1:0] ioWdata,
  input  logic              ioAck,
  input  logic [DATA_W-1:0] ioRdata
);

  strobeT            strobes;
  targetE            target;
  logic              busWe;
  logic [DATA_W-1:0] busWdata;

  busresp_control #(.TIMEOUT(TIMEOUT)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (cpuRead | cpuWrite),
    .isWrite   (cpuWrite),
    .target    (target),
    .memAck    (memAck),
    .ioAck     (ioAck),
    .strobes   (strobes),
    .memReq    (memReq),
    .ioReq     (ioReq),
    .busWe     (busWe),
    .cpuDone   (cpuDone),
    .cpuBusErr (cpuBusErr)
  );

  busresp_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PORT_W   (PORT_W),
    .REG_BASE (REG_BASE),
    .NUM_REGS (NUM_REGS),
    .WIN_BASE (WIN_BASE),
    .WIN_WORDS(WIN_WORDS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cpuAddr   (cpuAddr),
    .cpuWdata  (cpuWdata),
    .cpuIoSpace(cpuIoSpace),
    .strobes   (strobes),
    .memRdata  (memRdata),
    .ioRdata   (ioRdata),
    .target    (target),
    .memAddr   (memAddr),
    .ioAddr    (ioAddr),
    .busWdata  (busWdata),
    .rdata     (cpuRdata)
  );

  assign memWe    = memReq & busWe;
  assign ioWe     = ioReq & busWe;
  assign memWdata = busWdata;
  assign ioWdata  = busWdata;

endmodule

// File: rtl/bus_space_responder_chk.sv
module bus_space_responder_chk #(
  parameter int TIMEOUT = 4
) (
  input logic clk,
  input logic rstN,
  input logic cpuIoSpace,
  input logic cpuRead,
  input logic cpuWrite,
  input logic cpuDone,
  input logic cpuBusErr,
  input logic memReq,
  input logic memAck,
  input logic ioReq,
  input logic ioAck
);

  int unsigned memRun;
  int unsigned ioRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memRun <= 0;
      ioRun  <= 0;
    end else begin
      memRun <= memReq ? memRun + 1 : 0;
      ioRun  <= ioReq ? ioRun + 1 : 0;
    end
  end

  p_one_bus_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memReq, ioReq}));

  p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    cpuBusErr |-> cpuDone);

  p_mem_ack_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck) |=> (cpuDone && !cpuBusErr));

  p_fallback_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq || ioReq));

  p_mem_window_r5: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memRun < TIMEOUT));

  p_io_window_r7: assert property (@(posedge clk) disable iff (!rstN)
    ioReq |-> (ioRun < TIMEOUT));

  p_port_skips_mem_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuIoSpace && (cpuRead || cpuWrite) && !memReq && !ioReq) |=> !memReq);

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ioReq && !ioAck) |=> !memReq);

endmodule

bind bus_space_responder bus_space_responder_chk #(.TIMEOUT(TIMEOUT)) u_chk (.*);

// File: tb/bus_space_responder_test.sv
`timescale 1ns/1ps
module bus_space_responder_test;

  localparam int T = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic        cpuIoSpace = 1'b0;
  logic        cpuRead = 1'b0;
  logic        cpuWrite = 1'b0;
  logic [15:0] cpuWdata = '0;
  logic [15:0] cpuRdata;
  logic        cpuDone, cpuBusErr;
  logic        memReq, memWe, memAck = 1'b0;
  logic [15:0] memAddr, memWdata, memRdata;
  logic        ioReq, ioWe, ioAck = 1'b0;
  logic [15:0] ioAddr, ioWdata, ioRdata;

  int tests = 0;
  int fails = 0;
  int memDelay = 0;
  int ioDelay = 0;
  int memCnt = 0;
  int ioCnt = 0;
  bit finished = 1'b0;

  logic [15:0] regShadow [4];
  logic [15:0] bufShadow [16];
  logic [15:0] lastRd = '0;

  always #4 clk = ~clk;

  bus_space_responder uut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuIoSpace(cpuIoSpace),
    .cpuRead(cpuRead), .cpuWrite(cpuWrite), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .cpuDone(cpuDone), .cpuBusErr(cpuBusErr),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata),
    .ioReq(ioReq), .ioWe(ioWe), .ioAddr(ioAddr), .ioWdata(ioWdata),
    .ioAck(ioAck), .ioRdata(ioRdata)
  );

  function automatic bit memPop(logic [15:0] a);
    return a < 16'h8000;
  endfunction

  function automatic bit ioPop(logic [15:0] a);
    return a[7];
  endfunction

  assign memRdata = memAddr ^ 16'h5A5A;
  assign ioRdata  = ioAddr + 16'h1234;

  // Responders: acknowledge once, after the set delay, if the address is populated
  always @(negedge clk) begin
    if (memReq) begin
      memAck <= (memCnt == memDelay) && memPop(memAddr);
      memCnt <= memCnt + 1;
    end else begin
      memAck <= 1'b0;
      memCnt <= 0;
    end
    if (ioReq) begin
      ioAck <= (ioCnt == ioDelay) && ioPop(ioAddr);
      ioCnt <= ioCnt + 1;
    end else begin
      ioAck <= 1'b0;
      ioCnt <= 0;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Reference model: works out cycles and data from the address and responder setup
  task automatic access(input logic [15:0] a, input logic io, input logic rd,
                        input logic wr, input logic [15:0] wd, input string tag,
                        input int injectAt);
    int memC = 0;
    int ioC = 0;
    int lat = 1;
    bit err = 1'b0;
    bit toIo = 1'b0;
    logic [15:0] ioA = '0;
    logic [15:0] data = lastRd;
    logic [7:0] port = a[7:0];
    if (io && port >= 8'h40 && port < 8'h44) begin
      if (wr) regShadow[port - 8'h40] = wd;
      else data = regShadow[port - 8'h40];
    end else if (io) begin
      toIo = 1'b1;
      ioA = {8'h00, port};
    end else if (a >= 16'hF000 && a < 16'hF010) begin
      if (wr) bufShadow[a - 16'hF000] = wd;
      else data = bufShadow[a - 16'hF000];
    end else if (memPop(a) && memDelay < T) begin
      memC = memDelay + 1;
      lat = memC + 1;
      if (!wr) data = a ^ 16'h5A5A;
    end else begin
      memC = T;
      toIo = 1'b1;
      ioA = a;
    end
    if (toIo) begin
      if (ioPop(ioA) && ioDelay < T) begin
        ioC = ioDelay + 1;
        if (!wr) data = ioA + 16'h1234;
      end else begin
        ioC = T;
        err = 1'b1;
      end
      lat = memC + ioC + 1;
    end
    if (err) data = lastRd;
    @(negedge clk);
    cpuAddr = a; cpuIoSpace = io; cpuRead = rd; cpuWrite = wr; cpuWdata = wd;
    for (int n = 1; n <= lat + 1; n++) begin
      @(negedge clk);
      cpuRead = 1'b0; cpuWrite = 1'b0;
      if (injectAt > 0 && n == injectAt) begin
        cpuAddr = 16'hF000; cpuIoSpace = 1'b0; cpuRead = 1'b1;
      end
      // R8: exactly the expected bus is requested in each cycle
      check(memReq == (n <= memC), tag, $sformatf("memReq cycle %0d", n), memReq, n <= memC);
      check(ioReq == (n > memC && n <= memC + ioC), tag, $sformatf("ioReq cycle %0d", n),
            ioReq, n > memC && n <= memC + ioC);
      check(cpuDone == (n == lat), tag, $sformatf("cpuDone cycle %0d", n), cpuDone, n == lat);
      if (n == 1 && memC > 0) begin
        check(memAddr == a, tag, "memAddr", memAddr, a);
        check(memWe == wr, tag, "memWe", memWe, wr);
        if (wr) check(memWdata == wd, tag, "memWdata", memWdata, wd);
      end
      if (ioC > 0 && n == memC + 1) begin
        check(ioAddr == ioA, tag, "ioAddr", ioAddr, ioA);
        check(ioWe == wr, tag, "ioWe", ioWe, wr);
      end
      if (n == lat) begin
        check(cpuBusErr == err, tag, "cpuBusErr", cpuBusErr, err);
        check(cpuRdata == data, tag, "cpuRdata", cpuRdata, data);
      end
    end
    cpuRead = 1'b0;
    lastRd = data;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) regShadow[i] = '0;
    for (int i = 0; i < 16; i++) bufShadow[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!cpuDone && !cpuBusErr, "R1", "done/err", {cpuDone, cpuBusErr}, 0);
    check(!memReq && !ioReq, "R1", "requests", {memReq, ioReq}, 0);
    check(cpuRdata == 16'h0, "R1", "rdata", cpuRdata, 0);

    // R2: local control registers in port space
    access(16'h0041, 1, 0, 1, 16'h1111, "R2 wr", 0);
    access(16'h0041, 1, 1, 0, 16'h0000, "R2 rd", 0);
    access(16'h0043, 1, 0, 1, 16'hBEEF, "R2 wr top", 0);
    access(16'h0040, 1, 1, 0, 16'h0000, "R2 rd base", 0);
    // R11: upper address bits ignored in port space
    access(16'hAB43, 1, 1, 0, 16'h0000, "R11", 0);

    // R3: data buffer window
    access(16'hF005, 0, 0, 1, 16'h2222, "R3 wr", 0);
    access(16'hF00F, 0, 0, 1, 16'h3333, "R3 wr last", 0);
    access(16'hF005, 0, 1, 0, 16'h0000, "R3 rd", 0);
    access(16'hF00F, 0, 1, 0, 16'h0000, "R3 rd last", 0);

    // R4: memory bus answers
    memDelay = 0;
    access(16'h1234, 0, 1, 0, 16'h0000, "R4 fast", 0);
    memDelay = 2;
    access(16'h0100, 0, 1, 0, 16'h0000, "R4 slow", 0);
    access(16'h2000, 0, 0, 1, 16'h4444, "R4 wr", 0);
    memDelay = T - 1;
    access(16'h0010, 0, 1, 0, 16'h0000, "R4 last cycle", 0);

    // R5: fallback to the I/O bus
    memDelay = 0; ioDelay = 1;
    access(16'h9080, 0, 1, 0, 16'h0000, "R5 unmapped", 0);
    memDelay = T; ioDelay = 0;
    access(16'h0080, 0, 1, 0, 16'h0000, "R5 late mem", 0);

    // R6: port space outside registers goes only to the I/O bus
    ioDelay = 2;
    access(16'h0085, 1, 1, 0, 16'h0000, "R6 ext port", 0);
    access(16'h7F90, 1, 0, 1, 16'h5555, "R6 ext wr", 0);

    // R7: no answer anywhere
    memDelay = 0; ioDelay = 0;
    access(16'hF010, 0, 1, 0, 16'h0000, "R7 mem miss", 0);
    access(16'h0044, 1, 1, 0, 16'h0000, "R7 port miss", 0);
    access(16'h003F, 1, 1, 0, 16'h0000, "R7 port below", 0);

    // R9: strobe during an open access is ignored
    memDelay = 2;
    access(16'h0300, 0, 1, 0, 16'h0000, "R9 mem busy", 2);
    access(16'h0001, 1, 1, 0, 16'h0000, "R9 io busy", 3);

    // R10: read and write together act as a write and leave rdata alone
    access(16'h0042, 1, 1, 1, 16'h7777, "R10 both", 0);
    access(16'h0042, 1, 1, 0, 16'h0000, "R10 readback", 0);
    memDelay = 0;
    access(16'h0500, 0, 1, 1, 16'h8888, "R10 mem both", 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule